// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a received CAN frame is kept. It holds a small array of filter banks. Each bank has two 32-bit data words and a control word. A bank is set on its own to compare at either 32-bit or 16-bit scale, and in either mask mode or list mode. In mask mode a bank holds identifier/mask pairs. In list mode every field is an identifier that must match exactly.

A frame descriptor arrives with a valid strobe. The descriptor carries an 11-bit standard ID, the 18-bit extension of the extended ID, a format flag and a frame-type flag. One cycle later the block reports whether the frame was accepted, together with the global number of the lowest-numbered matching filter. Filter numbers run through the banks in bank order. Each bank adds 1, 2, 2 or 4 filters, according to its scale and mode.

Software-side configuration arrives through a narrow write port. The port has one enable per bank and a selector for the word to write.

Top module: `can_id_filter`

## Requirements
- R1: After reset every bank is inactive. Until a bank is configured, every evaluated frame gives acc_hit=0 and acc_fnum=0.
- R2: acc_valid is high for exactly the one cycle after each cycle with frm_valid high. When acc_valid is low, acc_hit and acc_fnum are 0.
- R3: 32-bit mask mode (control word 3'b101) packs the frame as {std[10:0], ext[17:0], format, type, 1'b0}. data0 is the identifier and data1 is the mask. A mask bit of 1 forces that bit to match, and a mask bit of 0 ignores it. The bank holds one filter.
- R4: 32-bit list mode (control word 3'b111) uses the same packing. data0 and data1 are each an exact identifier, numbered in that order, which gives two filters.
- R5: 16-bit mask mode (control word 3'b001) packs the frame as {std[10:0], type, format, ext[17:15]}. The low halves of data0 and data1 form the first ID/mask pair, and the high halves form the second.
- R6: 16-bit list mode (control word 3'b011) gives four exact identifiers, numbered in this order: data0 low half, data0 high half, data1 low half, data1 high half.
- R7: At 16-bit scale, extended-ID bits 14:0 of the frame have no effect on the result.
- R8: Filter numbers continue across banks in bank order. The count added by each bank is 1 (32-bit mask), 2 (32-bit list), 2 (16-bit mask) or 4 (16-bit list).
- R9: A bank whose active bit (control bit 0) is clear never matches. It still adds its filter count to the numbering of the banks after it.
- R10: When several filters match, acc_fnum reports the lowest filter number.
- R11: A configuration write in the same cycle as frm_valid does not affect that frame. The written value is used from the next evaluation onward. The cfg_sel encoding is 0 for data0, 1 for data1, 2 for the control word (bit 0 active, bit 1 list, bit 2 32-bit scale), and 3 writes nothing.
- R12: A frame that matches no filter gives acc_hit=0 and acc_fnum=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bank_en | input | NUM_BANKS | One write enable per bank |
| cfg_sel | input | 2 | Selects the word to write: data0, data1 or control |
| cfg_wdata | input | 32 | Write data |
| frm_valid | input | 1 | Frame descriptor strobe |
| frm_std_id | input | 11 | Standard identifier |
| frm_ext_id | input | 18 | Extended identifier extension bits |
| frm_ext | input | 1 | Format flag (1 = extended) |
| frm_rtr | input | 1 | Frame-type flag (1 = remote) |
| acc_valid | output | 1 | Result strobe, one cycle after frm_valid |
| acc_hit | output | 1 | Frame accepted |
| acc_fnum | output | FNUM_W | Global number of the lowest matching filter |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the very cycle a frame is evaluated. The bench has a task that drives the bank write and the frame strobe on the same falling edge. It then checks that the frame still sees the old identifier, and that the next frame sees the new one. Numbering across banks of mixed scale and mode is also hard to reach. To get there, the stimulus configures all four banks with different kinds, deactivates a bank in the middle, and then plants the same identifier in several filters so that priority decides the result.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  // Descriptor of the frame under evaluation
  typedef struct packed {
    logic [10:0] std_id;
    logic [17:0] ext_id;
    logic        fmt;
    logic        rtr;
  } frame_t;

  // Control word bit positions
  localparam int CTRL_ACTIVE = 0;
  localparam int CTRL_LIST   = 1;
  localparam int CTRL_WIDE   = 2;
  localparam int CTRL_W      = 3;

  // Write selector encoding
  localparam logic [1:0] SEL_DATA0 = 2'd0;
  localparam logic [1:0] SEL_DATA1 = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  // Bank interpretation, encoded as {wide, list}
  typedef enum logic [1:0] {
    BM_MASK16 = 2'b00,
    BM_LIST16 = 2'b01,
    BM_MASK32 = 2'b10,
    BM_LIST32 = 2'b11
  } bank_mode_e;

  localparam int MAX_PER_BANK = 4;
  localparam int CNT_W        = 3;

  function automatic logic [31:0] pack_wide(frame_t f);
    return {f.std_id, f.ext_id, f.fmt, f.rtr, 1'b0};
  endfunction

  function automatic logic [15:0] pack_half(frame_t f);
    return {f.std_id, f.rtr, f.fmt, f.ext_id[17:15]};
  endfunction

endpackage

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [31:0]             wr_data,
  input  frame_t                  frame,
  output logic [MAX_PER_BANK-1:0] hit_o,
  output logic [CNT_W-1:0]        count_o
);

  logic [31:0]       data0_q, data0_d;
  logic [31:0]       data1_q, data1_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ld_data0, ld_data1, ld_ctrl;

  assign ld_data0 = wr_en && (wr_sel == SEL_DATA0);
  assign ld_data1 = wr_en && (wr_sel == SEL_DATA1);
  assign ld_ctrl  = wr_en && (wr_sel == SEL_CTRL);

  always_comb begin
    data0_d = data0_q;
    data1_d = data1_q;
    ctrl_d  = ctrl_q;
    if (ld_data0) data0_d = wr_data;
    if (ld_data1) data1_d = wr_data;
    if (ld_ctrl)  ctrl_d  = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0_q <= '0;
      data1_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (ld_data0) data0_q <= data0_d;
      if (ld_data1) data1_q <= data1_d;
      if (ld_ctrl)  ctrl_q  <= ctrl_d;
    end
  end

  // Compare logic
  bank_mode_e              mode;
  logic [31:0]             key_w;
  logic [15:0]             key_h;
  logic [MAX_PER_BANK-1:0] raw_hit;

  assign mode  = bank_mode_e'({ctrl_q[CTRL_WIDE], ctrl_q[CTRL_LIST]});
  assign key_w = pack_wide(frame);
  assign key_h = pack_half(frame);

  always_comb begin
    raw_hit = '0;
    count_o = CNT_W'(1);
    unique case (mode)
      BM_MASK32: begin
        raw_hit[0] = ((key_w ^ data0_q) & data1_q) == 32'd0;
        count_o    = CNT_W'(1);
      end
      BM_LIST32: begin
        raw_hit[0] = key_w == data0_q;
        raw_hit[1] = key_w == data1_q;
        count_o    = CNT_W'(2);
      end
      BM_MASK16: begin
        raw_hit[0] = ((key_h ^ data0_q[15:0])  & data1_q[15:0])  == 16'd0;
        raw_hit[1] = ((key_h ^ data0_q[31:16]) & data1_q[31:16]) == 16'd0;
        count_o    = CNT_W'(2);
      end
      BM_LIST16: begin
        raw_hit[0] = key_h == data0_q[15:0];
        raw_hit[1] = key_h == data0_q[31:16];
        raw_hit[2] = key_h == data1_q[15:0];
        raw_hit[3] = key_h == data1_q[31:16];
        count_o    = CNT_W'(4);
      end
      default: begin
        raw_hit = '0;
        count_o = CNT_W'(1);
      end
    endcase
  end

  assign hit_o = ctrl_q[CTRL_ACTIVE] ? raw_hit : '0;

  // R9
  inactive_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CTRL_ACTIVE] |-> (hit_o == '0));

  // R8
  bank_count_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_W'(1)) || (count_o == CNT_W'(2)) || (count_o == CNT_W'(4)));

  // R8
  hit_within_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o >> count_o) == '0);

endmodule

// File: rtl/can_filt_select.sv
module can_filt_select
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int FNUM_W    = 5
) (
  input  logic [NUM_BANKS-1:0][MAX_PER_BANK-1:0] hits_i,
  input  logic [NUM_BANKS-1:0][CNT_W-1:0]        counts_i,
  output logic                                   any_o,
  output logic [FNUM_W-1:0]                      fnum_o
);

  logic [NUM_BANKS:0][FNUM_W-1:0]   base;
  logic [NUM_BANKS-1:0][1:0]        local_idx;
  logic [NUM_BANKS-1:0]             bank_any;

  assign base[0] = '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign base[b+1]   = base[b] + FNUM_W'(counts_i[b]);
    assign bank_any[b] = |hits_i[b];

    always_comb begin
      local_idx[b] = 2'd0;
      for (int k = MAX_PER_BANK - 1; k >= 0; k--) begin
        if (hits_i[b][k]) local_idx[b] = 2'(k);
      end
    end
  end

  always_comb begin
    any_o  = 1'b0;
    fnum_o = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bank_any[b]) begin
        any_o  = 1'b1;
        fnum_o = base[b] + FNUM_W'(local_idx[b]);
      end
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int FNUM_W    = $clog2(MAX_PER_BANK * NUM_BANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] cfg_bank_en,
  input  logic [1:0]           cfg_sel,
  input  logic [31:0]          cfg_wdata,
  input  logic                 frm_valid,
  input  logic [10:0]          frm_std_id,
  input  logic [17:0]          frm_ext_id,
  input  logic                 frm_ext,
  input  logic                 frm_rtr,
  output logic                 acc_valid,
  output logic                 acc_hit,
  output logic [FNUM_W-1:0]    acc_fnum
);

  localparam int MAX_FILT = MAX_PER_BANK * NUM_BANKS;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  frame_t frame;
  assign frame = '{std_id: frm_std_id, ext_id: frm_ext_id,
                   fmt: frm_ext, rtr: frm_rtr};

  logic [NUM_BANKS-1:0][MAX_PER_BANK-1:0] bank_hits;
  logic [NUM_BANKS-1:0][CNT_W-1:0]        bank_counts;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_banks
    can_filt_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (cfg_bank_en[b]),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .frame   (frame),
      .hit_o   (bank_hits[b]),
      .count_o (bank_counts[b])
    );
  end

  logic              sel_any;
  logic [FNUM_W-1:0] sel_fnum;

  can_filt_select #(
    .NUM_BANKS (NUM_BANKS),
    .FNUM_W    (FNUM_W)
  ) u_select (
    .hits_i   (bank_hits),
    .counts_i (bank_counts),
    .any_o    (sel_any),
    .fnum_o   (sel_fnum)
  );

  // Result register
  logic              res_en;
  logic              valid_d, hit_d;
  logic [FNUM_W-1:0] fnum_d;

  assign res_en = frm_valid | acc_valid;

  always_comb begin
    valid_d = frm_valid;
    hit_d   = frm_valid & sel_any;
    fnum_d  = (frm_valid & sel_any) ? sel_fnum : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_valid <= 1'b0;
      acc_hit   <= 1'b0;
      acc_fnum  <= '0;
    end else if (res_en) begin
      acc_valid <= valid_d;
      acc_hit   <= hit_d;
      acc_fnum  <= fnum_d;
    end
  end

  // R2
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    frm_valid |=> acc_valid);

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frm_valid |=> !acc_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc_valid |-> (!acc_hit && acc_fnum == '0));

  // R12
  miss_zero_num_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && !acc_hit) |-> (acc_fnum == '0));

  // R10
  fnum_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_hit |-> (acc_fnum < FNUM_W'(MAX_FILT)));

endmodule

// File: tb/tb_can_id_filter.sv
module tb_can_id_filter;

  localparam int NB = 4;
  localparam int FW = $clog2(4 * NB + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB-1:0] cfg_bank_en;
  logic [1:0]    cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          frm_valid;
  logic [10:0]   frm_std_id;
  logic [17:0]   frm_ext_id;
  logic          frm_ext, frm_rtr;
  logic          acc_valid, acc_hit;
  logic [FW-1:0] acc_fnum;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  can_id_filter #(.NUM_BANKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_bank_en(cfg_bank_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_std_id(frm_std_id),
    .frm_ext_id(frm_ext_id), .frm_ext(frm_ext), .frm_rtr(frm_rtr),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_fnum(acc_fnum)
  );

  function automatic logic [31:0] w32(input logic [10:0] s, input logic [17:0] e,
                                      input logic f, input logic r);
    return {s, e, f, r, 1'b0};
  endfunction

  function automatic logic [15:0] w16(input logic [10:0] s, input logic [2:0] eh,
                                      input logic f, input logic r);
    return {s, r, f, eh};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int bank, input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_bank_en = NB'(1) << bank;
    cfg_sel     = sel;
    cfg_wdata   = data;
    @(negedge clk);
    cfg_bank_en = '0;
  endtask

  task automatic drive_frame(input logic [10:0] s, input logic [17:0] e,
                             input logic f, input logic r);
    frm_valid  = 1'b1;
    frm_std_id = s;
    frm_ext_id = e;
    frm_ext    = f;
    frm_rtr    = r;
  endtask

  task automatic eval(input string req, input logic [10:0] s, input logic [17:0] e,
                      input logic f, input logic r, input int exp_hit, input int exp_num);
    @(negedge clk);
    drive_frame(s, e, f, r);
    @(negedge clk);
    frm_valid = 1'b0;
    chk({req, " valid"}, int'(acc_valid), 1);
    chk({req, " hit"}, int'(acc_hit), exp_hit);
    chk({req, " fnum"}, int'(acc_fnum), exp_num);
  endtask

  task automatic test_reset();
    chk("R1 reset valid", int'(acc_valid), 0);
    chk("R1 reset hit", int'(acc_hit), 0);
    eval("R1 unconfigured", 11'h123, 18'h0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic test_strobe();
    eval("R2 strobe", 11'h001, 18'h0, 1'b0, 1'b0, 0, 0);
    @(negedge clk);
    chk("R2 single cycle valid", int'(acc_valid), 0);
    chk("R2 idle hit", int'(acc_hit), 0);
    chk("R2 idle fnum", int'(acc_fnum), 0);
  endtask

  task automatic test_mask32();
    cfg_write(0, 2'd0, w32(11'h123, 18'h0, 1'b0, 1'b0));
    cfg_write(0, 2'd1, {11'h7FF, 21'h0});
    cfg_write(0, 2'd2, 32'h5);
    eval("R3 std match, ext ignored", 11'h123, 18'h3ABCD, 1'b1, 1'b1, 1, 0);
    eval("R3 std mismatch", 11'h124, 18'h0, 1'b0, 1'b0, 0, 0);
    cfg_write(0, 2'd1, {11'h7FF, 18'h0, 1'b0, 1'b1, 1'b0});
    eval("R3 type bit now enforced", 11'h123, 18'h0, 1'b0, 1'b1, 0, 0);
    eval("R3 type bit matches", 11'h123, 18'h0, 1'b0, 1'b0, 1, 0);
  endtask

  task automatic test_list32();
    cfg_write(1, 2'd0, w32(11'h055, 18'h01234, 1'b1, 1'b0));
    cfg_write(1, 2'd1, w32(11'h066, 18'h0, 1'b0, 1'b1));
    cfg_write(1, 2'd2, 32'h7);
    eval("R4 R8 second list entry", 11'h066, 18'h0, 1'b0, 1'b1, 1, 2);
    eval("R4 R8 first list entry", 11'h055, 18'h01234, 1'b1, 1'b0, 1, 1);
    eval("R4 ext bit differs", 11'h055, 18'h01235, 1'b1, 1'b0, 0, 0);
    eval("R4 format differs", 11'h066, 18'h0, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic test_mask16();
    cfg_write(2, 2'd0, {w16(11'h300, 3'b101, 1'b1, 1'b0), w16(11'h200, 3'b000, 1'b0, 1'b0)});
    cfg_write(2, 2'd1, {16'hFFFF, 16'hFFE0});
    cfg_write(2, 2'd2, 32'h1);
    eval("R5 low pair std only", 11'h200, 18'h3FFFF, 1'b1, 1'b1, 1, 3);
    eval("R5 R7 high pair, low ext ignored", 11'h300, 18'h2ABCD, 1'b1, 1'b0, 1, 4);
    eval("R7 ext 17:15 compared", 11'h300, 18'h0ABCD, 1'b1, 1'b0, 0, 0);
    eval("R5 high pair type enforced", 11'h300, 18'h28000, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic test_list16();
    cfg_write(3, 2'd0, {w16(11'h022, 3'b000, 1'b0, 1'b1), w16(11'h011, 3'b000, 1'b0, 1'b0)});
    cfg_write(3, 2'd1, {w16(11'h044, 3'b000, 1'b0, 1'b0), w16(11'h033, 3'b110, 1'b1, 1'b0)});
    cfg_write(3, 2'd2, 32'h3);
    eval("R6 R8 data0 low", 11'h011, 18'h00ABC, 1'b0, 1'b0, 1, 5);
    eval("R6 data0 high", 11'h022, 18'h0, 1'b0, 1'b1, 1, 6);
    eval("R6 R7 data1 low", 11'h033, 18'h37FFF, 1'b1, 1'b0, 1, 7);
    eval("R6 data1 high", 11'h044, 18'h0, 1'b0, 1'b0, 1, 8);
    eval("R12 no list match", 11'h045, 18'h0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic test_inactive();
    cfg_write(1, 2'd2, 32'h6);
    eval("R9 inactive bank silent", 11'h066, 18'h0, 1'b0, 1'b1, 0, 0);
    eval("R9 inactive bank still counted", 11'h200, 18'h0, 1'b0, 1'b0, 1, 3);
    eval("R9 later bank numbering", 11'h044, 18'h0, 1'b0, 1'b0, 1, 8);
    cfg_write(1, 2'd2, 32'h7);
    eval("R9 reactivated", 11'h066, 18'h0, 1'b0, 1'b1, 1, 2);
  endtask

  task automatic test_same_cycle_write();
    @(negedge clk);
    cfg_bank_en = NB'(1);
    cfg_sel     = 2'd0;
    cfg_wdata   = w32(11'h1AA, 18'h0, 1'b0, 1'b0);
    drive_frame(11'h123, 18'h0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_bank_en = '0;
    frm_valid   = 1'b0;
    chk("R11 collision uses old id hit", int'(acc_hit), 1);
    chk("R11 collision fnum", int'(acc_fnum), 0);
    eval("R11 old id gone", 11'h123, 18'h0, 1'b0, 1'b0, 0, 0);
    eval("R11 new id active", 11'h1AA, 18'h0, 1'b0, 1'b0, 1, 0);
    @(negedge clk);
    cfg_bank_en = NB'(4);
    cfg_sel     = 2'd3;
    cfg_wdata   = 32'h0;
    @(negedge clk);
    cfg_bank_en = '0;
    eval("R11 selector 3 writes nothing", 11'h200, 18'h0, 1'b0, 1'b0, 1, 3);
  endtask

  task automatic test_priority();
    cfg_write(3, 2'd1, {w16(11'h077, 3'b000, 1'b0, 1'b0), w16(11'h077, 3'b000, 1'b0, 1'b0)});
    eval("R10 two entries in bank", 11'h077, 18'h0, 1'b0, 1'b0, 1, 7);
    cfg_write(3, 2'd0, {w16(11'h022, 3'b000, 1'b0, 1'b1), w16(11'h1AA, 3'b000, 1'b0, 1'b0)});
    eval("R10 across banks", 11'h1AA, 18'h0, 1'b0, 1'b0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    cfg_bank_en = '0;
    cfg_sel     = '0;
    cfg_wdata   = '0;
    frm_valid   = 1'b0;
    frm_std_id  = '0;
    frm_ext_id  = '0;
    frm_ext     = 1'b0;
    frm_rtr     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_strobe();
    test_mask32();
    test_list32();
    test_mask16();
    test_list16();
    test_inactive();
    test_same_cycle_write();
    test_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule